// File: doc/BRIEF.md
# Global Control Register File for an Audio Streaming Interface

This block is the global register section of an audio streaming interface device. A host reaches it through a simple request port that carries quadlet reads, quadlet writes and a 64-bit compare-and-swap. It keeps four registers: the owner address, the notification word, the clock selection and the stream enable. It also answers status reads from the clock recovery logic. Every request is answered exactly one cycle after it is taken.

Single-cycle strobes report events from the outside: receive configuration changed, transmit configuration changed, and extended clock status changed. The block adds two events of its own: a change of the current-source lock, and the acceptance of a clock-select write. Each cycle that carries at least one event overwrites the notification word. When a host holds ownership, the same cycle also queues an outbound message that carries the owner address and the new event bits. A bus-reset strobe removes the owner and stops streaming.

Top module: `gctl_regs`

## Requirements
- R1: After reset and after every `bus_reset` strobe, the owner value is 0xFFFF_0000_0000_0000 (no owner). A read at offset 0x000 returns the upper quadlet (node ID in bits [63:48] of the owner), and a read at 0x004 returns the lower quadlet.
- R2: A plain write to the owner offsets has no effect. A compare-swap at 0x000 installs `req_data` only when `req_cmp` equals the current owner. In both cases the response carries the previous owner value.
- R3: `rsp_valid` is high in the single cycle after each accepted request and low otherwise. Reads of unmapped offsets and responses to writes return zero.
- R4: The notification word at 0x008 is read-only. Any cycle with one or more events replaces its whole content with exactly that cycle's event bits. Cycles without events leave it unchanged.
- R5: Event bit positions: bit0 receive configuration changed, bit1 transmit configuration changed, bit4 current-source lock changed (any toggle of `src_locked`), bit5 clock select accepted, bit6 extended status changed.
- R6: The clock select register at 0x04C holds the source code in bits [7:0] and the rate code in bits [15:8]. Bits [31:16] read as zero. A write raises event bit5 in the cycle after the write, so the notification word shows it two edges after the request.
- R7: A clock-select write is stored unchanged only when the source code is at most 0x0C and is marked in `SRC_CAPS`, and the rate code is at most 0x0A and is marked in `RATE_CAPS`. Any other write is stored as internal source at 48 kHz (0x020C), which is also the reset value.
- R8: A non-zero write to 0x050 sets `stream_en`. A zero write clears it. `bus_reset` clears it.
- R9: A read at 0x054 returns `src_locked` in bit0 and `nominal_rate` in bits [15:8]. A read at 0x058 returns `ext_status`.
- R10: An outbound message (`msg_valid`, `msg_addr` = owner, `msg_bits` = event bits) is raised only on an event cycle while an owner is present. It holds until `msg_ready` is high. A newer event replaces a pending message. `bus_reset` drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_reset | input | 1 | Serial bus reset strobe |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 compare-swap |
| req_addr | input | ADDR_W | Byte offset |
| req_cmp | input | 64 | Compare value for compare-swap |
| req_data | input | 64 | Write data (low quadlet) or swap value |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 64 | Read quadlet (zero-extended) or old owner |
| evt_rx_cfg | input | 1 | Receive configuration changed |
| evt_tx_cfg | input | 1 | Transmit configuration changed |
| evt_ext_status | input | 1 | Extended clock status changed |
| src_locked | input | 1 | Current clock source locked |
| nominal_rate | input | 8 | Measured nominal rate code |
| ext_status | input | 32 | Extended clock status word |
| stream_en | output | 1 | Stream enable |
| clk_source | output | 8 | Selected clock source code |
| clk_rate | output | 8 | Selected rate code |
| msg_valid | output | 1 | Outbound notification pending |
| msg_ready | input | 1 | Outbound notification taken |
| msg_addr | output | 64 | Owner address for the notification |
| msg_bits | output | 32 | Event bits of the notification |

## Verification
Some rules are checked by assertions on every cycle. The owner changes only through a matching compare-swap or a bus reset. A bus reset always leaves no owner and streaming stopped. The stored clock selection is always one the capabilities allow. A cycle without events never alters the notification word. A pending message stays stable until it is taken, and it never targets the no-owner address. Every request gets exactly one response, one cycle later. Some behaviour needs the bench's scenarios: which values the read mux returns, the exact substitution of unsupported selections, the replacement of notification bits across successive events, and the suppression of messages while no host is the owner.

// File: rtl/gctl_pkg.sv
package gctl_pkg;

  localparam int QW = 32;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CSWAP = 2'd2
  } gctl_op_e;

  localparam logic [63:0] NO_OWNER = 64'hFFFF_0000_0000_0000;

  localparam logic [11:0] OFF_OWNER_HI = 12'h000;
  localparam logic [11:0] OFF_OWNER_LO = 12'h004;
  localparam logic [11:0] OFF_NOTIFY   = 12'h008;
  localparam logic [11:0] OFF_CLKSEL   = 12'h04C;
  localparam logic [11:0] OFF_ENABLE   = 12'h050;
  localparam logic [11:0] OFF_STATUS   = 12'h054;
  localparam logic [11:0] OFF_EXTSTAT  = 12'h058;

  localparam int EV_RX     = 0;
  localparam int EV_TX     = 1;
  localparam int EV_LOCK   = 4;
  localparam int EV_ACCEPT = 5;
  localparam int EV_EXT    = 6;

  localparam logic [7:0] SRC_INTERNAL = 8'h0C;
  localparam logic [7:0] SRC_LAST     = 8'h0C;
  localparam logic [7:0] RATE_48K     = 8'h02;
  localparam logic [7:0] RATE_LAST    = 8'h0A;

  function automatic logic sel_ok(input logic [7:0] src, input logic [7:0] rate,
                                  input logic [15:0] src_caps, input logic [15:0] rate_caps);
    return (src <= SRC_LAST) && src_caps[src[3:0]] &&
           (rate <= RATE_LAST) && rate_caps[rate[3:0]];
  endfunction

  function automatic logic [15:0] sel_fix(input logic [15:0] word,
                                          input logic [15:0] src_caps, input logic [15:0] rate_caps);
    return sel_ok(word[7:0], word[15:8], src_caps, rate_caps) ? word : {RATE_48K, SRC_INTERNAL};
  endfunction

  function automatic logic [QW-1:0] status_word(input logic locked, input logic [7:0] rate);
    return {16'h0000, rate, 7'b0, locked};
  endfunction

endpackage

// File: rtl/gctl_owner.sv
module gctl_owner
  import gctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_reset,
  input  logic        cas_en,
  input  logic [63:0] cas_cmp,
  input  logic [63:0] cas_new,
  output logic [63:0] owner_q,
  output logic        cas_hit
);

  assign cas_hit = cas_en && (cas_cmp == owner_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         owner_q <= NO_OWNER;
    else if (bus_reset) owner_q <= NO_OWNER;
    else if (cas_hit)   owner_q <= cas_new;
  end

  AST_BUSRST_NO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> owner_q == NO_OWNER);                                  // R1
  AST_OWNER_ONLY_CSWAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cas_en || bus_reset) |=> $stable(owner_q));                        // R2

endmodule

// File: rtl/gctl_clksel.sv
module gctl_clksel
  import gctl_pkg::*;
#(
  parameter logic [15:0] SRC_CAPS  = 16'h1083,
  parameter logic [15:0] RATE_CAPS = 16'h007F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_word,
  output logic [15:0] sel_q,
  output logic        accept_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= {RATE_48K, SRC_INTERNAL};
      accept_q <= 1'b0;
    end else begin
      accept_q <= wr_en;
      if (wr_en) sel_q <= sel_fix(wr_word, SRC_CAPS, RATE_CAPS);
    end
  end

  AST_CLKSEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok(sel_q[7:0], sel_q[15:8], SRC_CAPS, RATE_CAPS));               // R7
  AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> accept_q);                                                 // R6

endmodule

// File: rtl/gctl_notify.sv
module gctl_notify
  import gctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic [QW-1:0] evt_vec,
  input  logic [63:0]   owner,
  input  logic          msg_ready,
  output logic [QW-1:0] notif_q,
  output logic          msg_valid,
  output logic [63:0]   msg_addr,
  output logic [QW-1:0] msg_bits
);

  logic any_evt;
  logic owned;
  assign any_evt = |evt_vec;
  assign owned   = (owner != NO_OWNER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       notif_q <= '0;
    else if (any_evt) notif_q <= evt_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= NO_OWNER;
      msg_bits  <= '0;
    end else if (bus_reset) begin
      msg_valid <= 1'b0;
    end else if (any_evt && owned) begin
      msg_valid <= 1'b1;
      msg_addr  <= owner;
      msg_bits  <= evt_vec;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  AST_NOTIF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(notif_q));                                      // R4
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && !any_evt && !bus_reset) |=>
      (msg_valid && $stable(msg_bits) && $stable(msg_addr)));            // R10
  AST_MSG_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr != NO_OWNER);                                 // R10

endmodule

// File: rtl/gctl_regs.sv
module gctl_regs
  import gctl_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [15:0] SRC_CAPS  = 16'h1083,
  parameter logic [15:0] RATE_CAPS = 16'h007F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_cmp,
  input  logic [63:0]       req_data,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  input  logic              evt_rx_cfg,
  input  logic              evt_tx_cfg,
  input  logic              evt_ext_status,
  input  logic              src_locked,
  input  logic [7:0]        nominal_rate,
  input  logic [QW-1:0]     ext_status,
  output logic              stream_en,
  output logic [7:0]        clk_source,
  output logic [7:0]        clk_rate,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [QW-1:0]     msg_bits
);

  localparam logic [ADDR_W-1:0] A_OWN_HI = ADDR_W'(OFF_OWNER_HI);
  localparam logic [ADDR_W-1:0] A_OWN_LO = ADDR_W'(OFF_OWNER_LO);
  localparam logic [ADDR_W-1:0] A_NOTIFY = ADDR_W'(OFF_NOTIFY);
  localparam logic [ADDR_W-1:0] A_CLKSEL = ADDR_W'(OFF_CLKSEL);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_EXTST  = ADDR_W'(OFF_EXTSTAT);

  // decoded request events
  logic rd_en, wr_en, cas_en_any;
  logic clk_wr_stb, en_wr_stb, cas_owner_stb;
  assign rd_en         = req_valid && (req_op == OP_READ);
  assign wr_en         = req_valid && (req_op == OP_WRITE);
  assign cas_en_any    = req_valid && (req_op == OP_CSWAP);
  assign clk_wr_stb    = wr_en && (req_addr == A_CLKSEL);
  assign en_wr_stb     = wr_en && (req_addr == A_ENABLE);
  assign cas_owner_stb = cas_en_any && (req_addr == A_OWN_HI);

  logic [63:0]   owner_q;
  logic          cas_hit;
  logic [15:0]   sel_q;
  logic          accept_q;
  logic [QW-1:0] notif_word;
  logic [QW-1:0] evt_vec;
  logic          locked_q;
  logic          lock_chg;
  logic          en_q;

  gctl_owner u_owner (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .cas_en(cas_owner_stb), .cas_cmp(req_cmp), .cas_new(req_data),
    .owner_q(owner_q), .cas_hit(cas_hit)
  );

  gctl_clksel #(.SRC_CAPS(SRC_CAPS), .RATE_CAPS(RATE_CAPS)) u_clksel (
    .clk(clk), .rst_n(rst_n), .wr_en(clk_wr_stb), .wr_word(req_data[15:0]),
    .sel_q(sel_q), .accept_q(accept_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b0;
    else        locked_q <= src_locked;
  end
  assign lock_chg = src_locked ^ locked_q;

  always_comb begin
    evt_vec            = '0;
    evt_vec[EV_RX]     = evt_rx_cfg;
    evt_vec[EV_TX]     = evt_tx_cfg;
    evt_vec[EV_LOCK]   = lock_chg;
    evt_vec[EV_ACCEPT] = accept_q;
    evt_vec[EV_EXT]    = evt_ext_status;
  end

  gctl_notify u_notify (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .evt_vec(evt_vec),
    .owner(owner_q), .msg_ready(msg_ready), .notif_q(notif_word),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_bits(msg_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= 1'b0;
    else if (bus_reset) en_q <= 1'b0;
    else if (en_wr_stb) en_q <= |req_data[QW-1:0];
  end

  logic [QW-1:0] rd_word;
  always_comb begin
    case (req_addr)
      A_OWN_HI: rd_word = owner_q[63:32];
      A_OWN_LO: rd_word = owner_q[31:0];
      A_NOTIFY: rd_word = notif_word;
      A_CLKSEL: rd_word = {16'h0000, sel_q};
      A_ENABLE: rd_word = {{(QW-1){1'b0}}, en_q};
      A_STATUS: rd_word = status_word(src_locked, nominal_rate);
      A_EXTST:  rd_word = ext_status;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (rd_en)              rsp_data <= {32'h0, rd_word};
      else if (cas_owner_stb) rsp_data <= owner_q;
      else                    rsp_data <= '0;
    end
  end

  assign stream_en  = en_q;
  assign clk_source = sel_q[7:0];
  assign clk_rate   = sel_q[15:8];

  AST_RSP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);                                            // R3
  AST_RSP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);                                          // R3
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    clk_wr_stb |-> ##2 notif_word[EV_ACCEPT]);                           // R6
  AST_ENABLE_BUSRST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !stream_en);                                           // R8
  AST_CAS_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_owner_stb && !cas_hit && !bus_reset) |=> $stable(owner_q));     // R2

endmodule

// File: tb/sim_gctl_regs.sv
module sim_gctl_regs;
  import gctl_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, bus_reset, req_valid;
  logic [1:0]  req_op;
  logic [11:0] req_addr;
  logic [63:0] req_cmp, req_data;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        evt_rx_cfg, evt_tx_cfg, evt_ext_status, src_locked;
  logic [7:0]  nominal_rate;
  logic [31:0] ext_status;
  logic        stream_en;
  logic [7:0]  clk_source, clk_rate;
  logic        msg_valid, msg_ready;
  logic [63:0] msg_addr;
  logic [31:0] msg_bits;

  gctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_cmp(req_cmp), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .evt_rx_cfg(evt_rx_cfg),
    .evt_tx_cfg(evt_tx_cfg), .evt_ext_status(evt_ext_status), .src_locked(src_locked),
    .nominal_rate(nominal_rate), .ext_status(ext_status), .stream_en(stream_en),
    .clk_source(clk_source), .clk_rate(clk_rate), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_bits(msg_bits)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [63:0] OWNER_A = 64'hFFC1_0000_0001_0000;

  // {write word, expected readback}
  localparam logic [63:0] CLK_VEC [8] = '{
    {32'h0000_0401, 32'h0000_0401},
    {32'h0000_0607, 32'h0000_0607},
    {32'h0000_0002, 32'h0000_020C},
    {32'h0000_070C, 32'h0000_020C},
    {32'h0000_000D, 32'h0000_020C},
    {32'hABCD_010C, 32'h0000_010C},
    {32'h0000_0B00, 32'h0000_020C},
    {32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] op, input logic [11:0] a, input logic [63:0] cmp,
                     input logic [63:0] d, output logic [63:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_cmp = cmp; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_data;
    chk("R3 rsp_valid after request", {63'b0, rsp_valid}, 64'd1);
    @(negedge clk);
    chk("R3 rsp_valid single cycle", {63'b0, rsp_valid}, 64'd0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] r);
    bus(2'd0, a, 64'h0, 64'h0, r);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [63:0] r;
    bus(2'd1, a, 64'h0, {32'h0, d}, r);
    chk("R3 write response zero", r, 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    rst_n = 1'b0; bus_reset = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0;
    req_cmp = '0; req_data = '0; evt_rx_cfg = 1'b0; evt_tx_cfg = 1'b0;
    evt_ext_status = 1'b0; src_locked = 1'b0; nominal_rate = 8'h00;
    ext_status = 32'h0; msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R8 stream_en reset", {63'b0, stream_en}, 64'd0);
    chk("R7 reset source internal", {56'b0, clk_source}, 64'h0C);
    chk("R7 reset rate 48k", {56'b0, clk_rate}, 64'h02);
    chk("R10 no message at reset", {63'b0, msg_valid}, 64'd0);
    rd(12'h000, r); chk("R1 owner hi at reset", r, 64'hFFFF_0000);
    rd(12'h004, r); chk("R1 owner lo at reset", r, 64'h0);
    rd(12'h100, r); chk("R3 unmapped read zero", r, 64'h0);

    // owner access
    wr(12'h000, 32'h1234_5678);
    rd(12'h000, r); chk("R2 plain write ignored", r, 64'hFFFF_0000);
    bus(2'd2, 12'h000, 64'h0, OWNER_A, r);
    chk("R2 cswap miss returns old", r, NO_OWNER);
    rd(12'h000, r); chk("R2 cswap miss no change", r, 64'hFFFF_0000);
    bus(2'd2, 12'h000, NO_OWNER, OWNER_A, r);
    chk("R2 cswap hit returns old", r, NO_OWNER);
    rd(12'h000, r); chk("R1 owner hi node id", r, {32'h0, OWNER_A[63:32]});
    rd(12'h004, r); chk("R1 owner lo", r, {32'h0, OWNER_A[31:0]});

    // clock select table
    msg_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wr(12'h04C, CLK_VEC[i][63:32]);
      rd(12'h04C, r); chk("R7 clock select stored", r, {32'h0, CLK_VEC[i][31:0]});
      chk("R6 source output", {56'b0, clk_source}, {56'b0, CLK_VEC[i][7:0]});
      rd(12'h008, r); chk("R6 accept event bit5", r, 64'h20);
    end
    repeat (3) @(negedge clk);
    msg_ready = 1'b0;

    // events and messages
    evt_rx_cfg = 1'b1; @(negedge clk); evt_rx_cfg = 1'b0;
    chk("R10 message raised", {63'b0, msg_valid}, 64'd1);
    chk("R10 message owner", msg_addr, OWNER_A);
    chk("R10 message bits rx", {32'h0, msg_bits}, 64'h1);
    rd(12'h008, r); chk("R4 notify rx only", r, 64'h1);
    evt_tx_cfg = 1'b1; evt_ext_status = 1'b1; @(negedge clk);
    evt_tx_cfg = 1'b0; evt_ext_status = 1'b0;
    chk("R10 pending replaced", {32'h0, msg_bits}, 64'h42);
    repeat (3) @(negedge clk);
    chk("R10 held without ready", {63'b0, msg_valid}, 64'd1);
    rd(12'h008, r); chk("R5 tx and ext bits", r, 64'h42);
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    chk("R10 taken on ready", {63'b0, msg_valid}, 64'd0);
    wr(12'h008, 32'hFF);
    rd(12'h008, r); chk("R4 notify read-only", r, 64'h42);

    // lock change and status
    src_locked = 1'b1; nominal_rate = 8'h04; ext_status = 32'h0003_0005;
    @(negedge clk);
    rd(12'h008, r); chk("R5 lock change bit4", r, 64'h10);
    rd(12'h054, r); chk("R9 status word", r, 64'h0401);
    rd(12'h058, r); chk("R9 extended status", r, 64'h0003_0005);
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;

    // enable and bus reset
    wr(12'h050, 32'h5); chk("R8 nonzero write sets", {63'b0, stream_en}, 64'd1);
    rd(12'h050, r); chk("R8 enable readback", r, 64'h1);
    wr(12'h050, 32'h0); chk("R8 zero write clears", {63'b0, stream_en}, 64'd0);
    wr(12'h050, 32'h1);
    evt_rx_cfg = 1'b1; @(negedge clk); evt_rx_cfg = 1'b0;
    bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
    chk("R8 bus reset clears enable", {63'b0, stream_en}, 64'd0);
    chk("R10 bus reset drops message", {63'b0, msg_valid}, 64'd0);
    rd(12'h000, r); chk("R1 bus reset no owner", r, 64'hFFFF_0000);

    // unowned event
    evt_rx_cfg = 1'b1; @(negedge clk); evt_rx_cfg = 1'b0;
    chk("R10 no message when unowned", {63'b0, msg_valid}, 64'd0);
    rd(12'h008, r); chk("R4 notify unowned event", r, 64'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule